// File: doc/BRIEF.md
# Software-Managed Address Translation Buffer

This block turns the virtual addresses of a processor's load and store stream into physical addresses. It uses a small, fully associative table of page mappings with 4 KiB pages, and software maintains the table. Each lookup carries a virtual address, an address-space tag and a privilege flag. One clock cycle later the block returns a physical address, a cacheable flag and a two-bit exception code. The virtual address of any lookup that faults is captured so that a handler can read it.

Software fills the table in two ways. It can set a staging register and issue a load command, which places the staged mapping in the next round-robin slot. It can also write any slot directly through an indexed entry port, and that port is the only way to read or delete slots. A four-bit control register enables translation, flushes the table, selects a single-virtual-space mode and holds an index-mode setting. Two fixed privileged windows of the address space are never translated.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, `rs_valid` is 0, `ctl_rdata` is 0, and every slot reads back as invalid through the entry port.
- R2: With the enable bit (control bit 0) at 0, a lookup outside the fixed windows returns the virtual address unchanged with cacheable 1 and exception code 0. This holds for any privilege and any access direction.
- R3: A virtual address whose top three bits are 100 bypasses translation with cacheable 1. A virtual address whose top three bits are 101 bypasses with cacheable 0. In both cases the physical address is the virtual address with bits 31:29 cleared, and the exception code is 0. This holds whether translation is enabled or not.
- R4: On a permitted hit the result is {PPN, vaddr[11:0]} with cacheable equal to the slot's C bit. Results appear on the cycle after `lk_valid`, and `rs_valid` is 0 on a cycle with no lookup before it.
- R5: A slot matches when it is valid, its VPN equals vaddr[31:12], and either its ASID equals `lk_asid` or its shared bit is 1. With single-virtual-space mode (control bit 2) set, the ASID is ignored.
- R6: An enabled lookup outside the fixed windows that matches no slot returns exception code 1, physical address 0 and cacheable 0.
- R7: Protection field bit 1 means privileged-only and bit 0 means writable. A user access to a privileged-only slot, or a write to a non-writable slot, returns code 2 for a read or code 3 for a write, with physical address 0 and cacheable 0.
- R8: In single-virtual-space mode, a user-mode hit on a slot whose shared bit is 0 raises the same protection codes. Shared slots remain usable from user mode.
- R9: `fault_vaddr` captures the virtual address of every lookup that returns a nonzero code and keeps its value across lookups that do not fault.
- R10: The load command writes the staged mapping, marked valid, into a round-robin slot. The slot starts at 0, advances by one per load, and wraps from 7 to 0.
- R11: An entry-port write sets every field of the addressed slot, and a write with valid 0 deletes the slot. The read outputs show the slot selected by `mm_idx`.
- R12: A control write with bit 1 set invalidates every slot and resets the round-robin slot to 0, effective from the next cycle. The same write updates bits 0, 2 and 3. Bit 1 always reads back as 0. A load command in the same cycle as a flush is discarded.
- R13: When several valid slots match, the lowest-index slot supplies the result and no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Address-space tag |
| lk_priv | input | 1 | 1 for privileged access |
| lk_write | input | 1 | 1 for a write access |
| rs_valid | output | 1 | Result valid (one cycle after request) |
| rs_paddr | output | 32 | Physical address |
| rs_cacheable | output | 1 | Cache may be used |
| rs_exc | output | 2 | 0 none, 1 miss, 2 read protection, 3 write protection |
| fault_vaddr | output | 32 | Virtual address of last faulting lookup |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 4 | Bit0 enable, bit1 flush, bit2 single-space, bit3 index mode |
| ctl_rdata | output | 4 | Control register readback (bit1 reads 0) |
| stg_we | input | 1 | Staging register write |
| stg_vpn | input | 20 | Staged virtual page number |
| stg_asid | input | 8 | Staged address-space tag |
| stg_ppn | input | 20 | Staged physical page number |
| stg_shared | input | 1 | Staged shared bit |
| stg_c | input | 1 | Staged cacheable bit |
| stg_prot | input | 2 | Staged protection field |
| ld_cmd | input | 1 | Load staged mapping into round-robin slot |
| mm_idx | input | 3 | Entry port slot index (read and write) |
| mm_we | input | 1 | Entry port write |
| mm_wvalid | input | 1 | Written valid bit |
| mm_wvpn | input | 20 | Written VPN |
| mm_wasid | input | 8 | Written ASID |
| mm_wppn | input | 20 | Written PPN |
| mm_wshared | input | 1 | Written shared bit |
| mm_wc | input | 1 | Written C bit |
| mm_wprot | input | 2 | Written protection field |
| mm_rvalid | output | 1 | Read valid bit of slot `mm_idx` |
| mm_rvpn | output | 20 | Read VPN |
| mm_rasid | output | 8 | Read ASID |
| mm_rppn | output | 20 | Read PPN |
| mm_rshared | output | 1 | Read shared bit |
| mm_rc | output | 1 | Read C bit |
| mm_rprot | output | 2 | Read protection field |

## Verification
A flush request and a load command can fall on the same clock edge, and both act on the slot array and the round-robin counter. The bench provokes this by raising `ctl_we` with bit 1 set and `ld_cmd` in one cycle, after the round-robin slot has moved away from 0. It judges the outcome at the ports: every slot must read back as invalid, the control readback must show the new mode bits, and the next lone load must land in slot 0. The multi-hit case is also built deliberately: a copy of a mapping is placed in a higher slot through the entry port, and the bench confirms that the lower slot's translation wins.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int ASID_W    = 8;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PROT_W    = 2;
  localparam int CTL_W     = 4;

  // control register bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_FLUSH = 1;
  localparam int CTL_SVM   = 2;
  localparam int CTL_IDX   = 3;

  // protection field bit positions
  localparam int PROT_WR   = 0;
  localparam int PROT_PRIV = 1;

  localparam logic [2:0] SEG_FIX_C = 3'b100;
  localparam logic [2:0] SEG_FIX_U = 3'b101;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_MISS    = 2'd1,
    EXC_PROT_RD = 2'd2,
    EXC_PROT_WR = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    RGN_MAPPED = 2'd0,
    RGN_FIX_C  = 2'd1,
    RGN_FIX_U  = 2'd2
  } rgn_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  ppn;
    logic              shared;
    logic              c;
    logic [PROT_W-1:0] prot;
  } tlb_entry_t;

  function automatic rgn_e f_region(input logic [VA_W-1:0] va);
    if (va[VA_W-1 -: 3] == SEG_FIX_C)      return RGN_FIX_C;
    else if (va[VA_W-1 -: 3] == SEG_FIX_U) return RGN_FIX_U;
    else                                   return RGN_MAPPED;
  endfunction

  function automatic logic [VA_W-1:0] f_bypass_pa(input logic [VA_W-1:0] va);
    return {3'b000, va[VA_W-4:0]};
  endfunction

  function automatic logic f_entry_hit(input tlb_entry_t e,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic [ASID_W-1:0] asid,
                                       input logic svm);
    return e.valid && (e.vpn == vpn) && (svm || e.shared || (e.asid == asid));
  endfunction

  function automatic logic f_prot_fault(input tlb_entry_t e, input logic priv,
                                        input logic wr, input logic svm);
    return (!priv && e.prot[PROT_PRIV]) ||
           (wr && !e.prot[PROT_WR]) ||
           (svm && !e.shared && !priv);
  endfunction
endpackage

// File: rtl/xlat_rr_ctr.sv
module xlat_rr_ctr #(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (clr)    ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R10
  rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  // R12
  rr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));
endmodule

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  tlb_entry_t       ld_ent,
  input  logic             mm_we,
  input  logic [IDX_W-1:0] mm_idx,
  input  tlb_entry_t       mm_ent,
  output tlb_entry_t       ent_arr [N_ENT],
  output logic [N_ENT-1:0] valid_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent_arr[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (flush)                                ent_arr[i].valid <= 1'b0;
        else if (ld_we && ld_idx == IDX_W'(i))   ent_arr[i] <= ld_ent;
        else if (mm_we && mm_idx == IDX_W'(i))   ent_arr[i] <= mm_ent;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) valid_vec[i] = ent_arr[i].valid;
  end

  // R12
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R10
  load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && !flush) |=> valid_vec[$past(ld_idx)]);
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlb_entry_t        ent_arr [N_ENT],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  input  logic              svm,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output tlb_entry_t        hit_ent
);
  logic [N_ENT-1:0] match_vec;
  logic [N_ENT-1:0] grant;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_vec[g] = f_entry_hit(ent_arr[g], vpn, asid, svm);
  end

  always_comb begin
    grant   = '0;
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match_vec[i] && !hit) begin
        grant[i] = 1'b1;
        hit      = 1'b1;
        hit_idx  = IDX_W'(i);
      end
    end
  end

  assign hit_ent = ent_arr[hit_idx];

  // R13
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (hit == (match_vec != '0)) && ((grant & match_vec) == grant));

  // R13
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & ((N_ENT'(1) << hit_idx) - 1'b1)) == '0));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [31:0]       lk_vaddr,
  input  logic [7:0]        lk_asid,
  input  logic              lk_priv,
  input  logic              lk_write,
  output logic              rs_valid,
  output logic [31:0]       rs_paddr,
  output logic              rs_cacheable,
  output logic [1:0]        rs_exc,
  output logic [31:0]       fault_vaddr,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  output logic [3:0]        ctl_rdata,
  input  logic              stg_we,
  input  logic [19:0]       stg_vpn,
  input  logic [7:0]        stg_asid,
  input  logic [19:0]       stg_ppn,
  input  logic              stg_shared,
  input  logic              stg_c,
  input  logic [1:0]        stg_prot,
  input  logic              ld_cmd,
  input  logic [IDX_W-1:0]  mm_idx,
  input  logic              mm_we,
  input  logic              mm_wvalid,
  input  logic [19:0]       mm_wvpn,
  input  logic [7:0]        mm_wasid,
  input  logic [19:0]       mm_wppn,
  input  logic              mm_wshared,
  input  logic              mm_wc,
  input  logic [1:0]        mm_wprot,
  output logic              mm_rvalid,
  output logic [19:0]       mm_rvpn,
  output logic [7:0]        mm_rasid,
  output logic [19:0]       mm_rppn,
  output logic              mm_rshared,
  output logic              mm_rc,
  output logic [1:0]        mm_rprot
);
  // control state
  logic ctl_en, ctl_svm, ctl_idx;
  logic flush_req;

  assign flush_req = ctl_we && ctl_wdata[CTL_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_svm <= 1'b0;
      ctl_idx <= 1'b0;
    end else if (ctl_we) begin
      ctl_en  <= ctl_wdata[CTL_EN];
      ctl_svm <= ctl_wdata[CTL_SVM];
      ctl_idx <= ctl_wdata[CTL_IDX];
    end
  end

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[CTL_EN]    = ctl_en;
    ctl_rdata[CTL_SVM]   = ctl_svm;
    ctl_rdata[CTL_IDX]   = ctl_idx;
  end

  // staging register
  tlb_entry_t stage_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (stg_we) begin
      stage_q.valid  <= 1'b1;
      stage_q.vpn    <= stg_vpn;
      stage_q.asid   <= stg_asid;
      stage_q.ppn    <= stg_ppn;
      stage_q.shared <= stg_shared;
      stage_q.c      <= stg_c;
      stage_q.prot   <= stg_prot;
    end
  end

  tlb_entry_t ld_ent, mm_ent;
  always_comb begin
    ld_ent       = stage_q;
    ld_ent.valid = 1'b1;
    mm_ent       = '{valid: mm_wvalid, vpn: mm_wvpn, asid: mm_wasid, ppn: mm_wppn,
                     shared: mm_wshared, c: mm_wc, prot: mm_wprot};
  end

  // replacement pointer
  logic [IDX_W-1:0] rr_ptr;
  logic             ld_go;
  assign ld_go = ld_cmd && !flush_req;

  xlat_rr_ctr #(.N_ENT(N_ENT)) u_rr (
    .clk(clk), .rst_n(rst_n), .clr(flush_req), .adv(ld_go), .ptr(rr_ptr)
  );

  // entry array
  tlb_entry_t       ent_arr [N_ENT];
  logic [N_ENT-1:0] valid_vec;

  xlat_entry_store #(.N_ENT(N_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_req),
    .ld_we(ld_cmd), .ld_idx(rr_ptr), .ld_ent(ld_ent),
    .mm_we(mm_we), .mm_idx(mm_idx), .mm_ent(mm_ent),
    .ent_arr(ent_arr), .valid_vec(valid_vec)
  );

  tlb_entry_t rd_ent;
  assign rd_ent     = ent_arr[mm_idx];
  assign mm_rvalid  = rd_ent.valid;
  assign mm_rvpn    = rd_ent.vpn;
  assign mm_rasid   = rd_ent.asid;
  assign mm_rppn    = rd_ent.ppn;
  assign mm_rshared = rd_ent.shared;
  assign mm_rc      = rd_ent.c;
  assign mm_rprot   = rd_ent.prot;

  // lookup
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  tlb_entry_t       hit_ent;

  xlat_match #(.N_ENT(N_ENT)) u_match (
    .clk(clk), .rst_n(rst_n), .ent_arr(ent_arr),
    .vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .asid(lk_asid), .svm(ctl_svm),
    .hit(hit), .hit_idx(hit_idx), .hit_ent(hit_ent)
  );

  rgn_e             rgn_now;
  exc_e             exc_now;
  logic [VA_W-1:0]  pa_now;
  logic             c_now;

  assign rgn_now = f_region(lk_vaddr);

  always_comb begin
    exc_now = EXC_NONE;
    pa_now  = '0;
    c_now   = 1'b0;
    if (rgn_now != RGN_MAPPED) begin
      pa_now = f_bypass_pa(lk_vaddr);
      c_now  = (rgn_now == RGN_FIX_C);
    end else if (!ctl_en) begin
      pa_now = lk_vaddr;
      c_now  = 1'b1;
    end else if (!hit) begin
      exc_now = EXC_MISS;
    end else if (f_prot_fault(hit_ent, lk_priv, lk_write, ctl_svm)) begin
      exc_now = lk_write ? EXC_PROT_WR : EXC_PROT_RD;
    end else begin
      pa_now = {hit_ent.ppn, lk_vaddr[PAGE_BITS-1:0]};
      c_now  = hit_ent.c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid     <= 1'b0;
      rs_paddr     <= '0;
      rs_cacheable <= 1'b0;
      rs_exc       <= '0;
      fault_vaddr  <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_paddr     <= pa_now;
        rs_cacheable <= c_now;
        rs_exc       <= exc_now;
        if (exc_now != EXC_NONE) fault_vaddr <= lk_vaddr;
      end
    end
  end

  // R2
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !ctl_en && rgn_now == RGN_MAPPED)
      |=> (rs_exc == EXC_NONE && rs_paddr == $past(lk_vaddr) && rs_cacheable));

  // R3
  fixed_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && rgn_now != RGN_MAPPED)
      |=> (rs_exc == EXC_NONE && rs_paddr[VA_W-1:VA_W-3] == 3'b000 &&
           rs_paddr[VA_W-4:0] == $past(lk_vaddr[VA_W-4:0])));

  // R6
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && ctl_en && rgn_now == RGN_MAPPED && !hit) |=> (rs_exc == EXC_MISS));

  // R9
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && exc_now != EXC_NONE) |=> (fault_vaddr == $past(lk_vaddr)));

  // R4
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  // R12
  flush_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CTL_FLUSH] == 1'b0);
endmodule

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        lk_valid, lk_priv, lk_write;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        rs_valid, rs_cacheable;
  logic [31:0] rs_paddr, fault_vaddr;
  logic [1:0]  rs_exc;
  logic        ctl_we;
  logic [3:0]  ctl_wdata, ctl_rdata;
  logic        stg_we, stg_shared, stg_c, ld_cmd;
  logic [19:0] stg_vpn, stg_ppn;
  logic [7:0]  stg_asid;
  logic [1:0]  stg_prot;
  logic [2:0]  mm_idx;
  logic        mm_we, mm_wvalid, mm_wshared, mm_wc;
  logic [19:0] mm_wvpn, mm_wppn;
  logic [7:0]  mm_wasid;
  logic [1:0]  mm_wprot;
  logic        mm_rvalid, mm_rshared, mm_rc;
  logic [19:0] mm_rvpn, mm_rppn;
  logic [7:0]  mm_rasid;
  logic [1:0]  mm_rprot;

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_priv(lk_priv), .lk_write(lk_write),
    .rs_valid(rs_valid), .rs_paddr(rs_paddr), .rs_cacheable(rs_cacheable),
    .rs_exc(rs_exc), .fault_vaddr(fault_vaddr),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stg_we(stg_we), .stg_vpn(stg_vpn), .stg_asid(stg_asid), .stg_ppn(stg_ppn),
    .stg_shared(stg_shared), .stg_c(stg_c), .stg_prot(stg_prot),
    .ld_cmd(ld_cmd),
    .mm_idx(mm_idx), .mm_we(mm_we), .mm_wvalid(mm_wvalid), .mm_wvpn(mm_wvpn),
    .mm_wasid(mm_wasid), .mm_wppn(mm_wppn), .mm_wshared(mm_wshared),
    .mm_wc(mm_wc), .mm_wprot(mm_wprot),
    .mm_rvalid(mm_rvalid), .mm_rvpn(mm_rvpn), .mm_rasid(mm_rasid),
    .mm_rppn(mm_rppn), .mm_rshared(mm_rshared), .mm_rc(mm_rc), .mm_rprot(mm_rprot)
  );

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [31:0] pa;
    logic        c;
    logic [1:0]  exc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rs_valid === 1'b1) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R4 unexpected result act=%h exp=none", rs_paddr);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " paddr"}, rs_paddr, e.pa);
        check({e.tag, " cacheable"}, {31'd0, rs_cacheable}, {31'd0, e.c});
        check({e.tag, " exc"}, {30'd0, rs_exc}, {30'd0, e.exc});
      end
    end
  end

  // own restatement of the bypass address
  function automatic logic [31:0] strip_seg(input logic [31:0] va);
    return va & 32'h1FFF_FFFF;
  endfunction

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic priv,
                        input logic wr, input logic [31:0] epa, input logic ec,
                        input logic [1:0] eexc, input string tag);
    exp_t e;
    @(negedge clk);
    e.pa = epa; e.c = ec; e.exc = eexc; e.tag = tag;
    sb_q.push_back(e);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_priv = priv; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic ctl_write(input logic [3:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic stage(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                       input logic sh, input logic c, input logic [1:0] prot);
    @(negedge clk);
    stg_we = 1'b1; stg_vpn = vpn; stg_asid = asid; stg_ppn = ppn;
    stg_shared = sh; stg_c = c; stg_prot = prot;
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  task automatic load(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                      input logic sh, input logic c, input logic [1:0] prot);
    stage(vpn, asid, ppn, sh, c, prot);
    @(negedge clk);
    ld_cmd = 1'b1;
    @(negedge clk);
    ld_cmd = 1'b0;
  endtask

  task automatic mm_write(input logic [2:0] idx, input logic v, input logic [19:0] vpn,
                          input logic [7:0] asid, input logic [19:0] ppn, input logic sh,
                          input logic c, input logic [1:0] prot);
    @(negedge clk);
    mm_we = 1'b1; mm_idx = idx; mm_wvalid = v; mm_wvpn = vpn; mm_wasid = asid;
    mm_wppn = ppn; mm_wshared = sh; mm_wc = c; mm_wprot = prot;
    @(negedge clk);
    mm_we = 1'b0;
  endtask

  task automatic mm_check(input logic [2:0] idx, input logic ev, input logic [19:0] evpn,
                          input logic [19:0] eppn, input string tag);
    @(negedge clk);
    mm_idx = idx;
    #1;
    check({tag, " slot valid"}, {31'd0, mm_rvalid}, {31'd0, ev});
    if (ev) begin
      check({tag, " slot vpn"}, {12'd0, mm_rvpn}, {12'd0, evpn});
      check({tag, " slot ppn"}, {12'd0, mm_rppn}, {12'd0, eppn});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_vaddr = 0; lk_asid = 0; lk_priv = 0; lk_write = 0;
    ctl_we = 0; ctl_wdata = 0;
    stg_we = 0; stg_vpn = 0; stg_asid = 0; stg_ppn = 0; stg_shared = 0; stg_c = 0; stg_prot = 0;
    ld_cmd = 0;
    mm_idx = 0; mm_we = 0; mm_wvalid = 0; mm_wvpn = 0; mm_wasid = 0; mm_wppn = 0;
    mm_wshared = 0; mm_wc = 0; mm_wprot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rs_valid", {31'd0, rs_valid}, 32'd0);
    check("R1 ctl_rdata", {28'd0, ctl_rdata}, 32'd0);
    for (int i = 0; i < 8; i++) mm_check(3'(i), 1'b0, '0, '0, "R1");

    // R2 disabled pass-through, user write, no exception
    lookup(32'h0040_1234, 8'd5, 1'b0, 1'b1, 32'h0040_1234, 1'b1, 2'd0, "R2 disabled");

    // R6 miss once enabled, R9 fault capture
    ctl_write(4'b0001);
    lookup(32'h0040_1234, 8'd5, 1'b0, 1'b0, 32'h0, 1'b0, 2'd1, "R6 miss");
    check("R9 fault after miss", fault_vaddr, 32'h0040_1234);

    // R3 fixed windows
    lookup(32'h8123_4560, 8'd5, 1'b1, 1'b0, strip_seg(32'h8123_4560), 1'b1, 2'd0, "R3 cached window");
    lookup(32'hA000_0010, 8'd5, 1'b1, 1'b1, strip_seg(32'hA000_0010), 1'b0, 2'd0, "R3 uncached window");

    // R10 load into slot 0, R4 hit translation
    load(20'h00401, 8'd5, 20'h12345, 1'b0, 1'b1, 2'b01);
    mm_check(3'd0, 1'b1, 20'h00401, 20'h12345, "R10 first load");
    lookup(32'h0040_1ABC, 8'd5, 1'b0, 1'b0, 32'h1234_5ABC, 1'b1, 2'd0, "R4 hit");
    check("R9 fault held", fault_vaddr, 32'h0040_1234);
    @(negedge clk);
    check("R4 idle rs_valid", {31'd0, rs_valid}, 32'd0);

    // R5 asid mismatch misses; shared slot matches any asid
    lookup(32'h0040_1ABC, 8'd6, 1'b0, 1'b0, 32'h0, 1'b0, 2'd1, "R5 asid mismatch");
    load(20'h00402, 8'd9, 20'h0AAAA, 1'b1, 1'b0, 2'b00);
    lookup(32'h0040_2008, 8'd3, 1'b0, 1'b0, 32'h0AAA_A008, 1'b0, 2'd0, "R5 shared hit");

    // R7 protection codes
    lookup(32'h0040_2008, 8'd3, 1'b0, 1'b1, 32'h0, 1'b0, 2'd3, "R7 write read-only");
    check("R9 fault after prot", fault_vaddr, 32'h0040_2008);
    load(20'h00403, 8'd5, 20'h00777, 1'b0, 1'b1, 2'b11);
    lookup(32'h0040_3010, 8'd5, 1'b0, 1'b0, 32'h0, 1'b0, 2'd2, "R7 user on priv-only");
    lookup(32'h0040_3010, 8'd5, 1'b1, 1'b1, 32'h0077_7010, 1'b1, 2'd0, "R7 priv write ok");

    // R13 duplicate mapping in slot 5; R11 entry port write/delete/read
    mm_write(3'd5, 1'b1, 20'h00401, 8'd5, 20'h55555, 1'b0, 1'b0, 2'b01);
    lookup(32'h0040_1ABC, 8'd5, 1'b0, 1'b0, 32'h1234_5ABC, 1'b1, 2'd0, "R13 lowest slot wins");
    mm_write(3'd0, 1'b0, 20'h00401, 8'd5, 20'h12345, 1'b0, 1'b1, 2'b01);
    mm_check(3'd0, 1'b0, '0, '0, "R11 delete");
    lookup(32'h0040_1ABC, 8'd5, 1'b0, 1'b0, 32'h5555_5ABC, 1'b0, 2'd0, "R11 after delete");
    mm_check(3'd5, 1'b1, 20'h00401, 20'h55555, "R11 read back");

    // R10 round robin continues at slot 3 and wraps to 0
    load(20'h01003, 8'd1, 20'h30003, 1'b0, 1'b1, 2'b01);
    mm_check(3'd3, 1'b1, 20'h01003, 20'h30003, "R10 slot 3");
    for (int k = 4; k < 9; k++) load(20'h01000 + 20'(k), 8'd1, 20'h30000 + 20'(k), 1'b0, 1'b1, 2'b01);
    mm_check(3'd7, 1'b1, 20'h01007, 20'h30007, "R10 slot 7");
    mm_check(3'd0, 1'b1, 20'h01008, 20'h30008, "R10 wrap to 0");

    // R12 flush with mode change; R8 single-space protection
    ctl_write(4'b0111);
    check("R12 ctl readback", {28'd0, ctl_rdata}, 32'h5);
    mm_check(3'd3, 1'b0, '0, '0, "R12 flushed slot 3");
    mm_check(3'd0, 1'b0, '0, '0, "R12 flushed slot 0");
    load(20'h00500, 8'd1, 20'h00ABC, 1'b0, 1'b1, 2'b01);
    mm_check(3'd0, 1'b1, 20'h00500, 20'h00ABC, "R12 pointer reset");
    lookup(32'h0050_0044, 8'd7, 1'b1, 1'b0, 32'h00AB_C044, 1'b1, 2'd0, "R5 single-space ignores asid");
    lookup(32'h0050_0044, 8'd7, 1'b0, 1'b0, 32'h0, 1'b0, 2'd2, "R8 user non-shared");
    load(20'h00501, 8'd2, 20'h00DEF, 1'b1, 1'b0, 2'b01);
    lookup(32'h0050_1100, 8'd7, 1'b0, 1'b0, 32'h00DE_F100, 1'b0, 2'd0, "R8 user shared ok");

    // R12 flush and load in the same cycle
    stage(20'h00600, 8'd1, 20'h00600, 1'b0, 1'b1, 2'b01);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 4'b1011; ld_cmd = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ld_cmd = 1'b0;
    check("R12 ctl readback idx mode", {28'd0, ctl_rdata}, 32'h9);
    for (int i = 0; i < 8; i++) mm_check(3'(i), 1'b0, '0, '0, "R12 flush beats load");
    lookup(32'h0060_0000, 8'd1, 1'b1, 1'b0, 32'h0, 1'b0, 2'd1, "R12 miss after flush");
    load(20'h00700, 8'd1, 20'h00707, 1'b0, 1'b1, 2'b01);
    mm_check(3'd0, 1'b1, 20'h00700, 20'h00707, "R12 next load slot 0");
    lookup(32'h0070_0FFF, 8'd1, 1'b0, 1'b1, 32'h0070_7FFF, 1'b1, 2'd0, "R4 hit after flush");

    // R2 disabled again: mapped address passes through
    ctl_write(4'b0000);
    lookup(32'h0070_0FFF, 8'd1, 1'b0, 1'b1, 32'h0070_0FFF, 1'b1, 2'd0, "R2 disabled bypasses table");
    lookup(32'hBFFF_FFF0, 8'd1, 1'b0, 1'b0, strip_seg(32'hBFFF_FFF0), 1'b0, 2'd0, "R3 uncached top");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", sb_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule